// File: doc/BRIEF.md
# Wake-up event controller

This block runs while the main system is powered down. It watches seven wake sources and raises a power-up request when an enabled source reports an event. The sources are:

- two serial keyboard/mouse style streams, each a clock and data pair;
- two modem ring indicator pins;
- a dedicated telephone ring pin;
- two general-purpose event pins.

A keyboard or mouse stream only wakes the system when its received bytes complete a byte sequence that software stored earlier. The ring pin can fire on one pulse, or only after a programmed number of pulses that arrive close enough together.

Every event lands in a sticky status bit, which software clears by writing one. The request output follows the enabled, set status bits, and can also be copied onto an interrupt line. A separate recovery bit covers power returning after a failure: if the stored recovery setting allows it, the request is raised automatically.

The block runs entirely on its own slow standby clock and samples every pin through a synchronizer. No data stream crosses its edge. The sequence table write port is a plain strobe that is accepted on every cycle, so there is no back-pressure anywhere.

Top module: `wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `evt_status`, `wake_req` and `wake_irq` are all zero.
- R2: A rising edge on `ri_a`, `ri_b`, `gpe_a` or `gpe_b` sets the status bit for that pin, and holding the pin high does not set the bit again. The bits are: `ri_a` bit 2, `ri_b` bit 3, `gpe_a` bit 5, `gpe_b` bit 6. The bit is set on the third rising clock edge after the pin rises (two synchronizer stages and the status register).
- R3: A set status bit stays set until a one is written to the same position of `sts_clr`. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: A status bit latches whether or not its source is enabled. `wake_req` is a register equal to the OR over bit positions of the previous cycle's `evt_status` ANDed with `{1'b1, evt_en}`. Bit 7 therefore always counts toward the request.
- R5: Each stream frame is sampled on the falling edges of its clock pin and has 11 bits: a start bit of 0, eight data bits sent LSB first, a parity bit making the nine bits odd, and a stop bit of 1. A 1 where the start bit should be is skipped. A frame with bad parity or a bad stop bit is dropped and does not change the match progress.
- R6: Each stream has its own table. Keyboard completion sets bit 0 and mouse completion sets bit 1. A length of 0 disables matching. For lengths 1 to 8, a byte equal to the next expected entry advances the progress, and completing the last entry fires the event and restarts. A byte that does not match restarts the progress: it counts as entry 0 if it equals entry 0, and otherwise the progress goes back to the start.
- R7: With `ring_train` low, every rising edge of `ring_in` sets status bit 4.
- R8: With `ring_train` high, ring rising edges are counted and bit 4 is set on the one that makes the count reach `ring_target`. If no further edge arrives within `ring_window`+1 cycles after the last counted one, the count returns to zero.
- R9: `wake_irq` equals `wake_req` when `irq_route_en` is high, and is low otherwise.
- R10: A rising edge of `pwr_back` sets status bit 7 only if `recov_en` is high. A rising edge while `recov_en` is low leaves bit 7 clear.
- R11: A cycle with `seq_we` high writes `seq_data` into entry `seq_addr` of the table that `seq_sel` picks: 0 for keyboard, 1 for mouse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kb_clk | input | 1 | Keyboard stream clock |
| kb_dat | input | 1 | Keyboard stream data |
| ms_clk | input | 1 | Mouse stream clock |
| ms_dat | input | 1 | Mouse stream data |
| ri_a | input | 1 | Ring indicator, serial port A |
| ri_b | input | 1 | Ring indicator, serial port B |
| ring_in | input | 1 | Dedicated ring pulse input |
| gpe_a | input | 1 | General-purpose event A |
| gpe_b | input | 1 | General-purpose event B |
| pwr_back | input | 1 | Main power returned after a failure |
| evt_en | input | 7 | Per-source enable, same bit order as status bits 0..6 |
| sts_clr | input | 8 | Write-one-to-clear strobes for the status bits |
| irq_route_en | input | 1 | Copy the request to the interrupt output |
| recov_en | input | 1 | Stored power-fail recovery setting |
| ring_train | input | 1 | 0 = single pulse, 1 = pulse train |
| ring_target | input | RCNT_W | Pulses needed in train mode |
| ring_window | input | RWIN_W | Largest gap between counted pulses, in cycles |
| seq_we | input | 1 | Sequence table write strobe |
| seq_sel | input | 1 | Table select: 0 keyboard, 1 mouse |
| seq_addr | input | clog2(SEQ_DEPTH) | Table entry |
| seq_data | input | 8 | Byte to store |
| kb_len | input | clog2(SEQ_DEPTH+1) | Keyboard sequence length |
| ms_len | input | clog2(SEQ_DEPTH+1) | Mouse sequence length |
| wake_req | output | 1 | Power-up request |
| wake_irq | output | 1 | Request routed to the interrupt line |
| evt_status | output | 8 | Sticky status bits |

## Verification
Internal state in this block is visible at the ports only through `evt_status` and, one cycle later, `wake_req`. A wrong bit count or shift register in a stream decoder therefore shows up as a missing or extra status bit, but only at the cycle after the last byte of a sequence. A wrong match pointer hides until the next sequence completes.

A wrong ring counter or gap timer shows up at the third pulse of a train, or at the first pulse after a long gap. For this reason every status bit and the request are compared on every cycle against a behavioural model. The stimulus includes dropped frames, partial matches and expired windows.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;
  localparam int N_SRC      = 7;
  localparam int N_STS      = N_SRC + 1;
  localparam int N_PIN      = 10;
  localparam int FRAME_BITS = 11;
  localparam int N_STREAM   = 2;

  // synchronized pin positions
  localparam int P_KCLK = 0;
  localparam int P_KDAT = 1;
  localparam int P_MCLK = 2;
  localparam int P_MDAT = 3;
  localparam int P_RIA  = 4;
  localparam int P_RIB  = 5;
  localparam int P_RING = 6;
  localparam int P_GPA  = 7;
  localparam int P_GPB  = 8;
  localparam int P_PWR  = 9;

  // status bit positions
  localparam int S_KB   = 0;
  localparam int S_MS   = 1;
  localparam int S_RIA  = 2;
  localparam int S_RIB  = 3;
  localparam int S_RING = 4;
  localparam int S_GPA  = 5;
  localparam int S_GPB  = 6;
  localparam int S_REC  = 7;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
  } rx_byte_t;
endpackage

// File: rtl/wake_sync.sv
`timescale 1ns/1ps
module wake_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int STAGES = 3;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], pin_i[b]};
    end
    assign lvl_o[b]  = sr[1];
    assign rise_o[b] = sr[1] & ~sr[2];
    assign fall_o[b] = ~sr[1] & sr[2];
  end
endmodule

// File: rtl/wake_ps2_rx.sv
`timescale 1ns/1ps
module wake_ps2_rx import wake_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall_i,
  input  logic     dat_i,
  output rx_byte_t rx_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] bitcnt;
  logic [8:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
      rx_o   <= '0;
    end else begin
      rx_o.vld <= 1'b0;
      if (fall_i) begin
        if (bitcnt == '0) begin
          if (!dat_i) bitcnt <= CW'(1);
        end else if (bitcnt == LAST) begin
          bitcnt <= '0;
          if (dat_i && (^sh)) begin
            rx_o.vld  <= 1'b1;
            rx_o.data <= sh[7:0];
          end
        end else begin
          sh     <= {dat_i, sh[8:1]};
          bitcnt <= bitcnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wake_seq_match.sv
`timescale 1ns/1ps
module wake_seq_match import wake_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rx_byte_t      rx_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [LW-1:0] len_i,
  output logic          hit_o
);
  logic [7:0]    tbl [DEPTH];
  logic [LW-1:0] idx, idx_nx;
  logic          cur_ok, first_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_addr] <= wr_data;
    end
  end

  assign cur_ok   = (idx < len_i) && (rx_i.data == tbl[idx[AW-1:0]]);
  assign first_ok = (rx_i.data == tbl[0]);

  always_comb begin
    hit_o  = 1'b0;
    idx_nx = idx;
    if (rx_i.vld && len_i != '0) begin
      if (cur_ok) begin
        if (idx == len_i - LW'(1)) begin
          hit_o  = 1'b1;
          idx_nx = '0;
        end else begin
          idx_nx = idx + LW'(1);
        end
      end else if (first_ok) begin
        if (len_i == LW'(1)) begin
          hit_o  = 1'b1;
          idx_nx = '0;
        end else begin
          idx_nx = LW'(1);
        end
      end else begin
        idx_nx = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_nx;
  end
endmodule

// File: rtl/wake_ring_det.sv
`timescale 1ns/1ps
module wake_ring_det #(
  parameter int CNT_W = 4,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             train_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [WIN_W-1:0] tmr, tmr_nx;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);

  always_comb begin
    evt_o  = 1'b0;
    cnt_nx = cnt;
    tmr_nx = tmr;
    if (!train_i) begin
      evt_o  = rise_i;
      cnt_nx = '0;
      tmr_nx = '0;
    end else if (rise_i) begin
      tmr_nx = '0;
      if (cnt_inc >= {1'b0, target_i}) begin
        evt_o  = 1'b1;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt_inc[CNT_W-1:0];
      end
    end else if (cnt != '0) begin
      if (tmr == window_i) begin
        cnt_nx = '0;
        tmr_nx = '0;
      end else begin
        tmr_nx = tmr + WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmr <= '0;
    end else begin
      cnt <= cnt_nx;
      tmr <= tmr_nx;
    end
  end
endmodule

// File: rtl/wake_ctrl.sv
`timescale 1ns/1ps
module wake_ctrl import wake_pkg::*; #(
  parameter int SEQ_DEPTH = 8,
  parameter int RCNT_W    = 4,
  parameter int RWIN_W    = 16,
  localparam int SAW = $clog2(SEQ_DEPTH),
  localparam int SLW = $clog2(SEQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_clk,
  input  logic              kb_dat,
  input  logic              ms_clk,
  input  logic              ms_dat,
  input  logic              ri_a,
  input  logic              ri_b,
  input  logic              ring_in,
  input  logic              gpe_a,
  input  logic              gpe_b,
  input  logic              pwr_back,
  input  logic [N_SRC-1:0]  evt_en,
  input  logic [N_STS-1:0]  sts_clr,
  input  logic              irq_route_en,
  input  logic              recov_en,
  input  logic              ring_train,
  input  logic [RCNT_W-1:0] ring_target,
  input  logic [RWIN_W-1:0] ring_window,
  input  logic              seq_we,
  input  logic              seq_sel,
  input  logic [SAW-1:0]    seq_addr,
  input  logic [7:0]        seq_data,
  input  logic [SLW-1:0]    kb_len,
  input  logic [SLW-1:0]    ms_len,
  output logic              wake_req,
  output logic              wake_irq,
  output logic [N_STS-1:0]  evt_status
);
  logic [N_PIN-1:0]    pins, lvl, rise, fall;
  logic [N_STREAM-1:0] hit, rx_vld;
  logic [SLW-1:0]      len_arr [N_STREAM];
  rx_byte_t            rx_s    [N_STREAM];
  logic                ring_evt;
  logic [N_STS-1:0]    evt;
  logic                unused_sync;

  assign pins = {pwr_back, gpe_b, gpe_a, ring_in, ri_b, ri_a,
                 ms_dat, ms_clk, kb_dat, kb_clk};
  assign unused_sync = ^{lvl, rise, fall};

  wake_sync #(.W(N_PIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign len_arr[0] = kb_len;
  assign len_arr[1] = ms_len;

  for (genvar s = 0; s < N_STREAM; s++) begin : g_stream
    wake_ps2_rx u_rx (
      .clk(clk), .rst_n(rst_n),
      .fall_i(fall[P_KCLK + 2*s]), .dat_i(lvl[P_KDAT + 2*s]),
      .rx_o(rx_s[s])
    );
    assign rx_vld[s] = rx_s[s].vld;

    wake_seq_match #(.DEPTH(SEQ_DEPTH)) u_match (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_s[s]),
      .wr_en(seq_we && (seq_sel == 1'(s))),
      .wr_addr(seq_addr), .wr_data(seq_data),
      .len_i(len_arr[s]), .hit_o(hit[s])
    );
  end

  wake_ring_det #(.CNT_W(RCNT_W), .WIN_W(RWIN_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .rise_i(rise[P_RING]),
    .train_i(ring_train), .target_i(ring_target),
    .window_i(ring_window), .evt_o(ring_evt)
  );

  always_comb begin
    evt         = '0;
    evt[S_KB]   = hit[0];
    evt[S_MS]   = hit[1];
    evt[S_RIA]  = rise[P_RIA];
    evt[S_RIB]  = rise[P_RIB];
    evt[S_RING] = ring_evt;
    evt[S_GPA]  = rise[P_GPA];
    evt[S_GPB]  = rise[P_GPB];
    evt[S_REC]  = rise[P_PWR] & recov_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_status <= '0;
      wake_req   <= 1'b0;
    end else begin
      evt_status <= (evt_status & ~sts_clr) | evt;
      wake_req   <= |(evt_status & {1'b1, evt_en});
    end
  end

  assign wake_irq = wake_req & irq_route_en;
endmodule

// File: rtl/wake_ctrl_chk.sv
`timescale 1ns/1ps
module wake_ctrl_chk import wake_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic [N_STS-1:0] sts,
  input logic [N_STS-1:0] clr,
  input logic             req,
  input logic             recov,
  input logic [1:0]       rx_vld
);
  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~clr) != '0) |=> (((($past(sts) & ~$past(clr))) & ~sts) == '0));

  // R4
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(sts != '0));

  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |=> !req);

  // R5
  kb_frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld[0] |=> !rx_vld[0]);

  // R5
  ms_frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld[1] |=> !rx_vld[1]);

  // R10
  recov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[S_REC]) |-> $past(recov));
endmodule

bind wake_ctrl wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sts(evt_status), .clr(sts_clr),
  .req(wake_req), .recov(recov_en), .rx_vld(rx_vld)
);

// File: tb/wake_ctrl_test.sv
`timescale 1ns/1ps
module wake_ctrl_test;
  localparam int DEPTH = 8, CW = 4, WW = 16;
  localparam int AW = $clog2(DEPTH), LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic kb_clk, kb_dat, ms_clk, ms_dat, ri_a, ri_b, ring_in, gpe_a, gpe_b, pwr_back;
  logic [6:0] evt_en;
  logic [7:0] sts_clr;
  logic irq_route_en, recov_en, ring_train, seq_we, seq_sel;
  logic [CW-1:0] ring_target;
  logic [WW-1:0] ring_window;
  logic [AW-1:0] seq_addr;
  logic [7:0] seq_data;
  logic [LW-1:0] kb_len, ms_len;
  logic wake_req, wake_irq;
  logic [7:0] evt_status;

  wake_ctrl #(.SEQ_DEPTH(DEPTH), .RCNT_W(CW), .RWIN_W(WW)) uut (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [9:0] h1, h2, h3, pv, m_rise, m_fall, m_lvl;
  int m_bits [2];
  logic [8:0] m_sh [2];
  bit m_pend [2], n_pend [2];
  int m_pbyte [2], n_pbyte [2];
  int m_idx [2];
  int m_tbl [2][DEPTH];
  int m_rc, m_rt, len;
  logic [7:0] m_sts, m_evt;
  logic m_req;

  always @(posedge clk) begin
    pv = {pwr_back, gpe_b, gpe_a, ring_in, ri_b, ri_a, ms_dat, ms_clk, kb_dat, kb_clk};
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      for (int s = 0; s < 2; s++) begin
        m_bits[s] = 0; m_sh[s] = '0; m_pend[s] = 0; m_pbyte[s] = 0; m_idx[s] = 0;
        for (int i = 0; i < DEPTH; i++) m_tbl[s][i] = 0;
      end
      m_rc = 0; m_rt = 0; m_sts = '0; m_req = 0;
    end else begin
      m_rise = h2 & ~h3;
      m_fall = ~h2 & h3;
      m_lvl  = h2;
      m_evt  = '0;
      for (int s = 0; s < 2; s++) begin
        // matcher consumes the byte framed on the previous edge
        len = (s == 0) ? int'(kb_len) : int'(ms_len);
        if (m_pend[s] && len != 0) begin
          if (m_idx[s] < len && m_pbyte[s] == m_tbl[s][m_idx[s]]) begin
            if (m_idx[s] == len - 1) begin m_evt[s] = 1; m_idx[s] = 0; end
            else m_idx[s]++;
          end else if (m_pbyte[s] == m_tbl[s][0]) begin
            if (len == 1) begin m_evt[s] = 1; m_idx[s] = 0; end
            else m_idx[s] = 1;
          end else m_idx[s] = 0;
        end
        n_pend[s] = 0; n_pbyte[s] = m_pbyte[s];
        if (m_fall[2*s]) begin
          if (m_bits[s] == 0) begin
            if (!m_lvl[2*s+1]) m_bits[s] = 1;
          end else if (m_bits[s] == 10) begin
            m_bits[s] = 0;
            if (m_lvl[2*s+1] && ($countones(m_sh[s]) % 2 == 1)) begin
              n_pend[s] = 1; n_pbyte[s] = int'(m_sh[s][7:0]);
            end
          end else begin
            m_sh[s] = {m_lvl[2*s+1], m_sh[s][8:1]};
            m_bits[s]++;
          end
        end
      end
      for (int s = 0; s < 2; s++) begin m_pend[s] = n_pend[s]; m_pbyte[s] = n_pbyte[s]; end
      // ring
      if (!ring_train) begin
        m_evt[4] = m_rise[6]; m_rc = 0; m_rt = 0;
      end else if (m_rise[6]) begin
        m_rt = 0;
        if (m_rc + 1 >= int'(ring_target)) begin m_evt[4] = 1; m_rc = 0; end
        else m_rc++;
      end else if (m_rc != 0) begin
        if (m_rt == int'(ring_window)) begin m_rc = 0; m_rt = 0; end
        else m_rt++;
      end
      m_evt[2] = m_rise[4]; m_evt[3] = m_rise[5];
      m_evt[5] = m_rise[7]; m_evt[6] = m_rise[8];
      m_evt[7] = m_rise[9] & recov_en;
      if (seq_we) m_tbl[seq_sel][seq_addr] = int'(seq_data);
      m_req = |(m_sts & {1'b1, evt_en});
      m_sts = (m_sts & ~sts_clr) | m_evt;
      h3 = h2; h2 = h1; h1 = pv;
    end
    #1;
    chk("R3/R4 model evt_status", int'(evt_status), int'(m_sts));
    chk("R4 model wake_req", int'(wake_req), int'(m_req));
    chk("R9 model wake_irq", int'(wake_irq), int'(m_req & irq_route_en));
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic p);
    p = 1'b1; tick(4); p = 1'b0; tick(4);
  endtask

  task automatic clear(logic [7:0] m);
    sts_clr = m; tick(1); sts_clr = '0; tick(3);
  endtask

  task automatic wr(bit sel, int addr, logic [7:0] d);
    seq_we = 1; seq_sel = sel; seq_addr = AW'(addr); seq_data = d;
    tick(1); seq_we = 0;
  endtask

  task automatic send(bit s, logic [7:0] b, bit bad);
    logic [10:0] fr;
    fr = {1'b1, (bad ? ^b : ~^b), b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      if (s) ms_dat = fr[i]; else kb_dat = fr[i];
      tick(3);
      if (s) ms_clk = 1'b0; else kb_clk = 1'b0;
      tick(4);
      if (s) ms_clk = 1'b1; else kb_clk = 1'b1;
      tick(4);
    end
    if (s) ms_dat = 1'b1; else kb_dat = 1'b1;
    tick(4);
  endtask

  initial begin
    rst_n = 0;
    kb_clk = 1; kb_dat = 1; ms_clk = 1; ms_dat = 1;
    ri_a = 0; ri_b = 0; ring_in = 0; gpe_a = 0; gpe_b = 0; pwr_back = 0;
    evt_en = '1; sts_clr = '0; irq_route_en = 0; recov_en = 0;
    ring_train = 0; ring_target = 4'd3; ring_window = 16'd40;
    seq_we = 0; seq_sel = 0; seq_addr = '0; seq_data = '0; kb_len = '0; ms_len = '0;
    tick(4);
    chk("R1 status in reset", int'(evt_status), 0);
    chk("R1 req in reset", int'(wake_req), 0);
    chk("R1 irq in reset", int'(wake_irq), 0);
    rst_n = 1; tick(6);

    pulse(ri_a);
    chk("R2 ri_a sets bit 2", int'(evt_status), 8'h04);
    chk("R4 request raised", int'(wake_req), 1);
    chk("R9 irq off when not routed", int'(wake_irq), 0);
    clear(8'h04);
    chk("R3 clear bit 2", int'(evt_status), 0);
    chk("R4 request dropped", int'(wake_req), 0);

    gpe_a = 1; tick(6);
    chk("R2 gpe_a sets bit 5", int'(evt_status[5]), 1);
    clear(8'h20); tick(6);
    chk("R2 held level no retrigger", int'(evt_status[5]), 0);
    gpe_a = 0; tick(4);

    evt_en = 7'h3F; pulse(gpe_b);
    chk("R4 disabled source still latches", int'(evt_status[6]), 1);
    chk("R4 disabled source no request", int'(wake_req), 0);
    evt_en = '1; tick(2);
    chk("R4 enabling raises request", int'(wake_req), 1);
    clear(8'h40);

    sts_clr = 8'h20; pulse(gpe_a); sts_clr = '0; tick(2);
    chk("R3 clear held while event", int'(evt_status[5]), 0);

    irq_route_en = 1; pulse(ri_b);
    chk("R9 irq follows request", int'(wake_irq), 1);
    irq_route_en = 0; tick(1);
    chk("R9 irq gated off", int'(wake_irq), 0);
    clear(8'h08);

    wr(0, 0, 8'h1C); wr(0, 1, 8'h32); kb_len = LW'(2);
    wr(1, 0, 8'hAA);
    send(0, 8'h1C, 0); send(0, 8'h32, 0);
    chk("R6 R11 keyboard sequence match", int'(evt_status[0]), 1);
    clear(8'h01);
    send(0, 8'h1C, 0); send(0, 8'h1C, 0); send(0, 8'h32, 0);
    chk("R6 restart on repeated first byte", int'(evt_status[0]), 1);
    clear(8'h01);
    send(0, 8'h32, 0);
    chk("R6 lone second byte no match", int'(evt_status[0]), 0);
    send(0, 8'h1C, 0); send(0, 8'h32, 1);
    chk("R5 bad parity frame dropped", int'(evt_status[0]), 0);
    send(0, 8'h32, 0);
    chk("R5 dropped frame keeps progress", int'(evt_status[0]), 1);
    clear(8'h01);

    send(1, 8'hAA, 0);
    chk("R6 mouse length zero disabled", int'(evt_status[1]), 0);
    ms_len = LW'(1);
    send(1, 8'hAA, 0);
    chk("R6 R11 mouse single byte match", int'(evt_status[1]), 1);
    clear(8'h02);

    pulse(ring_in);
    chk("R7 single ring pulse", int'(evt_status[4]), 1);
    clear(8'h10);
    ring_train = 1;
    pulse(ring_in); pulse(ring_in);
    chk("R8 two of three pulses", int'(evt_status[4]), 0);
    pulse(ring_in);
    chk("R8 third pulse wakes", int'(evt_status[4]), 1);
    clear(8'h10);
    pulse(ring_in); pulse(ring_in); tick(100); pulse(ring_in);
    chk("R8 window expiry restarts count", int'(evt_status[4]), 0);
    pulse(ring_in); pulse(ring_in);
    chk("R8 fresh train wakes", int'(evt_status[4]), 1);
    clear(8'h10); ring_train = 0;

    pulse(pwr_back);
    chk("R10 recovery off ignored", int'(evt_status[7]), 0);
    recov_en = 1; evt_en = '0;
    pulse(pwr_back);
    chk("R10 recovery sets bit 7", int'(evt_status[7]), 1);
    chk("R10 recovery request regardless of enables", int'(wake_req), 1);
    clear(8'h80);
    chk("R3 recovery bit cleared", int'(evt_status), 0);
    tick(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule